// File: doc/BRIEF.md
# Lane-Partitioned Vector Equality Mask Unit

This block compares two packed vector operands lane by lane and returns a mask vector. Each lane of the mask is as wide as the operand lanes. It holds all ones where the two lanes match and all zeros where they do not. A run-time size code picks the lane width. A second control picks an operand width of 64 or 128 bits. Another control switches between bitwise integer equality and single-precision floating-point equality. A last control compares each lane of the first operand against zero instead of against the second operand.

The 128-bit form is built from two identical 64-bit half comparators. The 64-bit form uses only the low half. Results are registered once, so the mask for inputs presented in one cycle is visible after the next rising clock edge. The mask is the only result. No flag or other status comes out of the compare. The single exception is a flag that marks an illegal size and mode combination.

Top module: `simd_eq_mask`

## Requirements
- R1: Each mask lane has the width of the selected operand lane. It is all ones when the two operand lanes are equal and all zeros otherwise.
- R2: In integer mode, `lane_size` 2'b00 selects 8-bit lanes, 2'b01 selects 16-bit lanes and 2'b10 selects 32-bit lanes. The comparison is bitwise, so signedness has no effect.
- R3: With `quad_form`=1, all 128 bits are compared as two 64-bit halves. With `quad_form`=0, only bits [63:0] are compared and mask bits [127:64] are zero.
- R4: With `vs_zero`=1, each lane of `opa` is compared against zero, and the value of `opb` has no effect on the mask.
- R5: In floating-point mode (`fp_mode`=1), lanes are 32-bit IEEE single-precision values (sign bit 31, exponent bits 30:23, fraction bits 22:0). The only legal `lane_size` is 2'b10.
- R6: In floating-point mode, a lane whose operand is a NaN (exponent all ones, nonzero fraction) compares unequal. This holds for every NaN, including a NaN compared with an identical bit pattern.
- R7: In floating-point mode, +0.0 equals -0.0. A denormal (exponent zero, nonzero fraction) is treated as a zero of the same sign before the compare, so it equals any zero or any other denormal.
- R8: An illegal configuration is integer mode with `lane_size`=2'b11, or floating-point mode with any `lane_size` other than 2'b10. On an illegal configuration, `cfg_illegal` is 1 and the whole mask is zero. Otherwise `cfg_illegal` is 0.
- R9: Outputs are registered. The result for inputs sampled at a rising edge appears after that edge. While `rst_n` is low, `mask` and `cfg_illegal` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opa | input | 128 | First operand vector |
| opb | input | 128 | Second operand vector (ignored when vs_zero=1) |
| lane_size | input | 2 | Lane width code |
| fp_mode | input | 1 | 1 = single-precision float compare, 0 = integer |
| quad_form | input | 1 | 1 = 128-bit operands, 0 = 64-bit operands |
| vs_zero | input | 1 | 1 = compare opa lanes against zero |
| mask | output | 128 | Registered per-lane equality mask |
| cfg_illegal | output | 1 | Registered illegal-configuration flag |

## Verification
The bench changes a single byte near a lane boundary at each lane size. A design that partitions lanes wrongly clears the wrong neighbouring bytes or too few of them. Floating-point vectors place NaN against an identical NaN, +0 against -0, and denormals against zero. A bitwise comparator would mark the NaN lane equal and the signed-zero and denormal lanes unequal. Double-form runs put junk in the upper operand halves to expose leakage into mask bits [127:64]. Compare-with-zero runs put junk in `opb`, and reserved size codes must yield an all-zero mask with the flag raised.

// File: rtl/simd_eq_pkg.sv
package simd_eq_pkg;

    typedef enum logic [1:0] {
        LSZ_8   = 2'b00,
        LSZ_16  = 2'b01,
        LSZ_32  = 2'b10,
        LSZ_RSV = 2'b11
    } lane_sz_e;

    localparam int unsigned FP_W   = 32;
    localparam int unsigned EXP_HI = 30;
    localparam int unsigned EXP_LO = 23;

endpackage

// File: rtl/simd_fp32_eq.sv
module simd_fp32_eq
    import simd_eq_pkg::*;
(
    input  logic [FP_W-1:0] a,
    input  logic [FP_W-1:0] b,
    output logic            eq
);
    localparam int unsigned EXP_W = EXP_HI - EXP_LO + 1;

    logic [EXP_W-1:0]  exp_a, exp_b;
    logic [EXP_LO-1:0] frac_a, frac_b;
    logic              nan_a, nan_b, zero_a, zero_b;

    always_comb begin
        exp_a  = a[EXP_HI:EXP_LO];
        exp_b  = b[EXP_HI:EXP_LO];
        frac_a = a[EXP_LO-1:0];
        frac_b = b[EXP_LO-1:0];
        nan_a  = (&exp_a) && (|frac_a);
        nan_b  = (&exp_b) && (|frac_b);
        // exponent zero covers true zeros and flushed denormals
        zero_a = (exp_a == '0);
        zero_b = (exp_b == '0);
        eq     = !nan_a && !nan_b && ((zero_a && zero_b) || (a == b));
    end
endmodule

// File: rtl/simd_eq_half.sv
module simd_eq_half
    import simd_eq_pkg::*;
#(
    parameter int unsigned HALF_W = 64
) (
    input  logic [HALF_W-1:0] a,
    input  logic [HALF_W-1:0] b,
    input  logic [1:0]        lane_size,
    input  logic              fp_mode,
    output logic [HALF_W-1:0] m
);
    localparam int unsigned NB = HALF_W / 8;
    localparam int unsigned NW = HALF_W / FP_W;

    logic [NB-1:0] byte_eq, half_eq, word_eq, fp_eq_b, sel;
    logic [NW-1:0] fp_eq;

    for (genvar w = 0; w < NW; w++) begin : g_fp
        simd_fp32_eq u_fp (
            .a  (a[w*FP_W +: FP_W]),
            .b  (b[w*FP_W +: FP_W]),
            .eq (fp_eq[w])
        );
    end

    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign byte_eq[g] = (a[g*8 +: 8] == b[g*8 +: 8]);
        assign half_eq[g] = byte_eq[g] & byte_eq[g ^ 1];
        assign word_eq[g] = &byte_eq[(g/4)*4 +: 4];
        assign fp_eq_b[g] = fp_eq[g/4];
        assign m[g*8 +: 8] = {8{sel[g]}};
    end

    always_comb begin
        if (fp_mode) begin
            sel = fp_eq_b;
        end else begin
            unique case (lane_sz_e'(lane_size))
                LSZ_8:   sel = byte_eq;
                LSZ_16:  sel = half_eq;
                LSZ_32:  sel = word_eq;
                default: sel = '0;
            endcase
        end
    end
endmodule

// File: rtl/simd_eq_mask.sv
module simd_eq_mask
    import simd_eq_pkg::*;
#(
    parameter int unsigned HALF_W = 64,
    parameter int unsigned DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [1:0]        lane_size,
    input  logic              fp_mode,
    input  logic              quad_form,
    input  logic              vs_zero,
    output logic [DATA_W-1:0] mask,
    output logic              cfg_illegal
);
    localparam int unsigned NHALF = DATA_W / HALF_W;
    localparam int unsigned NWORD = DATA_W / FP_W;

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic              bad;
    } state_t;

    state_t            st_d, st_q;
    logic [DATA_W-1:0] cmp_b, half_m;
    logic              illegal;

    assign cmp_b = vs_zero ? '0 : opb;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        simd_eq_half #(.HALF_W(HALF_W)) u_half (
            .a         (opa[h*HALF_W +: HALF_W]),
            .b         (cmp_b[h*HALF_W +: HALF_W]),
            .lane_size (lane_size),
            .fp_mode   (fp_mode),
            .m         (half_m[h*HALF_W +: HALF_W])
        );
    end

    always_comb begin
        illegal = fp_mode ? (lane_sz_e'(lane_size) != LSZ_32)
                          : (lane_sz_e'(lane_size) == LSZ_RSV);
        st_d      = '0;
        st_d.bad  = illegal;
        if (!illegal) begin
            st_d.mask = half_m;
            if (!quad_form) st_d.mask[DATA_W-1:HALF_W] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask        = st_q.mask;
    assign cfg_illegal = st_q.bad;

    // R8: illegal configuration gives flag and empty mask
    a_r8_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_mode ? (lane_size != 2'b10) : (lane_size == 2'b11))
        |=> (cfg_illegal && mask == '0));

    // R3: double form leaves upper mask clear
    a_r3_double_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !quad_form |=> (mask[DATA_W-1:HALF_W] == '0));

    // R2: identical integer operands give a full mask
    a_r2_equal_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (!fp_mode && lane_size != 2'b11 && quad_form && !vs_zero && opa == opb)
        |=> (&mask));

    // R6: NaN in the low lane of opa never matches
    a_r6_nan_unequal: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_mode && lane_size == 2'b10 && (&opa[30:23]) && (|opa[22:0]))
        |=> (mask[31:0] == '0));

    // R5: float lanes are whole 32-bit words
    for (genvar w = 0; w < NWORD; w++) begin : g_chk
        a_r5_fp_word_uniform: assert property (@(posedge clk) disable iff (!rst_n)
            (fp_mode && lane_size == 2'b10)
            |=> (mask[w*FP_W +: FP_W] == '0 || (&mask[w*FP_W +: FP_W])));
    end

    // R9: reset clears outputs
    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (mask == '0 && !cfg_illegal));
endmodule

// File: tb/tb_simd_eq_mask.sv
module tb_simd_eq_mask;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] opa = '0, opb = '0;
    logic [1:0]   lane_size = 2'b00;
    logic         fp_mode = 1'b0, quad_form = 1'b1, vs_zero = 1'b0;
    logic [127:0] mask;
    logic         cfg_illegal;
    int           total = 0, bad = 0;

    always #4 clk = ~clk;

    simd_eq_mask dut (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .lane_size(lane_size),
        .fp_mode(fp_mode), .quad_form(quad_form), .vs_zero(vs_zero),
        .mask(mask), .cfg_illegal(cfg_illegal)
    );

    function automatic logic fp_same(logic [31:0] x, logic [31:0] y);
        logic nx, ny, zx, zy;
        nx = (x[30:23] == 8'hFF) && (x[22:0] != 0);
        ny = (y[30:23] == 8'hFF) && (y[22:0] != 0);
        zx = (x[30:23] == 8'h00);
        zy = (y[30:23] == 8'h00);
        return !nx && !ny && ((zx && zy) || x == y);
    endfunction

    function automatic logic [127:0] ref_mask(logic [127:0] a, logic [127:0] b,
            logic [1:0] sz, logic fp, logic q, logic zc);
        logic [127:0] r = '0;
        int w, nl;
        logic [31:0] lm, ea, eb;
        logic hit;
        if (fp ? (sz != 2'b10) : (sz == 2'b11)) return '0;
        w  = fp ? 32 : (8 << sz);
        nl = (q ? 128 : 64) / w;
        lm = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
        for (int i = 0; i < nl; i++) begin
            ea  = 32'(a >> (i*w)) & lm;
            eb  = zc ? 32'h0 : (32'(b >> (i*w)) & lm);
            hit = fp ? fp_same(ea, eb) : (ea == eb);
            if (hit) r = r | (128'(lm) << (i*w));
        end
        return r;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic apply(logic [127:0] a, logic [127:0] b, logic [1:0] sz,
                         logic fp, logic q, logic zc);
        @(negedge clk);
        opa = a; opb = b; lane_size = sz; fp_mode = fp; quad_form = q; vs_zero = zc;
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [127:0] got, logic [127:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic check_ref(string tag);
        logic exp_bad;
        exp_bad = fp_mode ? (lane_size != 2'b10) : (lane_size == 2'b11);
        check(tag, mask, ref_mask(opa, opb, lane_size, fp_mode, quad_form, vs_zero));
        check({tag, " flag"}, {127'b0, cfg_illegal}, {127'b0, exp_bad});
    endtask

    task automatic t_reset();
        @(posedge clk); #1;
        check("R9 reset mask", mask, '0);
        check("R9 reset flag", {127'b0, cfg_illegal}, '0);
    endtask

    // R1 R2 R3: random and equal-by-construction vectors, all sizes, both forms
    task automatic t_int_random();
        logic [127:0] a, b;
        for (int sz = 0; sz < 3; sz++) begin
            for (int q = 0; q < 2; q++) begin
                for (int n = 0; n < 20; n++) begin
                    a = rnd128();
                    b = (n % 2) ? rnd128() : (a ^ (rnd128() & rnd128() & rnd128()));
                    if (n % 5 == 0) b = a;
                    apply(a, b, 2'(sz), 1'b0, 1'(q), 1'b0);
                    check_ref($sformatf("R1 R2 R3 int sz=%0d q=%0d", sz, q));
                end
            end
        end
    endtask

    // R2: one byte differs, explicit expected masks per lane size
    task automatic t_lane_boundary();
        logic [127:0] a;
        a = rnd128();
        apply(a, a ^ (128'h01 << 24), 2'b00, 1'b0, 1'b1, 1'b0);
        check("R2 byte3 size8", mask, ~(128'hFF << 24));
        apply(a, a ^ (128'h80 << 24), 2'b01, 1'b0, 1'b1, 1'b0);
        check("R2 byte3 size16", mask, ~(128'hFFFF << 16));
        apply(a, a ^ (128'h10 << 40), 2'b10, 1'b0, 1'b1, 1'b0);
        check("R2 byte5 size32", mask, ~(128'hFFFF_FFFF << 32));
        apply(a, a ^ (128'h01 << 64), 2'b10, 1'b0, 1'b1, 1'b0);
        check("R3 upper half differ", mask, ~(128'hFFFF_FFFF << 64));
        apply(a, {rnd128() | (128'h1 << 100)} ^ {64'h0, 64'h0} | 128'h0, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R3 double upper zero", mask & {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, '0);
        apply({64'hDEAD_BEEF_0000_1111, 64'h1234}, {64'h0, 64'h1234}, 2'b01, 1'b0, 1'b0, 1'b0);
        check("R3 double ignores upper", mask, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF});
    endtask

    // R4: compare against zero with junk on opb
    task automatic t_zero_cmp();
        apply({64'h0, 64'h00FF_0000_1200_0001}, rnd128(), 2'b00, 1'b0, 1'b0, 1'b1);
        check("R4 int zero size8", mask, {64'h0, 64'hFF00_FFFF_00FF_FF00});
        apply({32'h3F80_0000, 32'h8000_0000, 32'h8000_0005, 32'h7FC0_0000, 64'h0},
              rnd128(), 2'b10, 1'b1, 1'b1, 1'b1);
        check("R4 R7 fp zero", mask,
              {32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF});
        for (int n = 0; n < 10; n++) begin
            apply(rnd128() & rnd128() & rnd128(), rnd128(), 2'(n % 3), 1'b0, 1'b1, 1'b1);
            check_ref("R4 int zero random");
        end
    endtask

    // R5 R6 R7: float special values
    task automatic t_fp_special();
        apply({32'h7F80_0000, 32'h7FC0_0000, 32'h8000_0000, 32'h0000_0001,
               32'h7F80_0001, 32'h3F80_0000, 32'h8000_0003, 32'h4000_0000},
              {32'h7F80_0000, 32'h7FC0_0000, 32'h0000_0000, 32'h0000_0000,
               32'h7F80_0001, 32'h3F80_0000, 32'h0000_0007, 32'hC000_0000},
              2'b10, 1'b1, 1'b1, 1'b0);
        check("R5 R6 R7 fp specials", mask,
              {32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
               32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0});
        check("R5 fp flag", {127'b0, cfg_illegal}, '0);
        for (int n = 0; n < 20; n++) begin
            logic [127:0] a;
            a = rnd128();
            apply(a, (n % 2) ? a : rnd128(), 2'b10, 1'b1, 1'(n % 3 != 0), 1'b0);
            check_ref("R5 R6 fp random");
        end
    endtask

    // R8: reserved size codes
    task automatic t_illegal();
        logic [127:0] a;
        a = rnd128();
        apply(a, a, 2'b11, 1'b0, 1'b1, 1'b0);
        check("R8 int size11 mask", mask, '0);
        check("R8 int size11 flag", {127'b0, cfg_illegal}, 128'h1);
        for (int sz = 0; sz < 4; sz++) begin
            if (sz == 2) continue;
            apply(a, a, 2'(sz), 1'b1, 1'b1, 1'b0);
            check_ref($sformatf("R8 fp size %0d", sz));
        end
        apply(a, a, 2'b10, 1'b0, 1'b1, 1'b0);
        check("R8 flag clears", {127'b0, cfg_illegal}, '0);
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_int_random();
        t_lane_boundary();
        t_zero_cmp();
        t_fp_special();
        t_illegal();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule